// File: doc/BRIEF.md
# Wait-for-Event Register and Wake-Up Control

This block holds the one-bit event flag that decides whether a wait-for-event (WFE) instruction puts a small processor core to sleep. Several kinds of activity set the flag. Send-event pulses set it, whether they come from this core or from another one. A pending interrupt that newly appears sets it while the send-on-pending enable is on. Exception entry and exception exit set it. A debug event sets it while debug is enabled. A receive-event line also sets it. That line is decoded from a 3-bit interrupt-status code and a halted flag.

When a WFE request arrives and the flag is set, the flag is consumed and the core keeps running. When the flag is clear, the core goes to sleep. It stays asleep until any set condition occurs. At that point the core wakes, emits a one-cycle wake pulse and clears the flag.

Entry, exit and debug activity all feed the flag. An interrupt taken and serviced just before a WFE therefore leaves the flag set, so the following WFE cannot sleep forever.

Top module: `evreg_wake_top`

## Requirements
- R1: After reset, `sleeping_o` and `wake_o` are low and the event flag is clear, so a first WFE request puts the core to sleep.
- R2: A pulse on `sev_local_i` or on `sev_remote_i` sets the event flag.
- R3: A 0-to-1 transition of any bit of `pend_i` sets the flag only while `sev_on_pend_i` is high. A pending bit held high sets the flag once, on its first high cycle. Rising bits while the enable is low have no effect.
- R4: A pulse on `exc_entry_i` or on `exc_exit_i` sets the event flag.
- R5: `dbg_event_i` sets the flag only while `dbg_en_i` is high.
- R6: The receive-event term is active while `halted_i` is high. It is also active while `trace_pwr_i` is high and `istat_code_i` equals 3'b001 or 3'b010. Any other code, or any code while `trace_pwr_i` is low, has no effect.
- R7: A WFE request while awake with the flag set clears the flag and does not sleep, so a second WFE with no new event sleeps.
- R8: A WFE request while awake with the flag clear and no set condition in the same cycle raises `sleeping_o` at the next clock edge.
- R9: While asleep, a set condition makes `sleeping_o` fall and `wake_o` pulse high for exactly one cycle at the next edge. It also clears the flag. WFE requests while asleep are ignored.
- R10: When a set condition and a WFE request occur in the same cycle while awake, the set wins. The core does not sleep, and the flag is left set.
- R11: An exception entered and exited before a WFE leaves the flag set, so that WFE does not sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sev_local_i | input | 1 | Send-event pulse from this core |
| sev_remote_i | input | 1 | Send-event pulse from another core |
| pend_i | input | NUM_IRQ | Per-interrupt pending levels |
| sev_on_pend_i | input | 1 | Enables pending-edge events |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_exit_i | input | 1 | Exception exit strobe |
| dbg_event_i | input | 1 | Debug event strobe |
| dbg_en_i | input | 1 | Debug enable |
| istat_code_i | input | CODE_W | Interrupt-status code |
| trace_pwr_i | input | 1 | Qualifies the status code |
| halted_i | input | 1 | Core halted by debug |
| wfe_req_i | input | 1 | WFE request |
| sleeping_o | output | 1 | Core is asleep |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The bench targets the edges of the priority rule. It drives a set condition in the same cycle as a WFE request. A design that let the clear win would drop that event, and the core would sleep on the following WFE.

It holds a pending bit high across many cycles. Level rather than edge detection would keep setting the flag, and a later WFE would never sleep. It also presents status codes other than 001 and 010, and the two valid codes with the trace enable low. A loose decode would wake the core or keep it from sleeping.

After every wake it issues a WFE with no new event. A design that did not clear the flag on wake would fail to sleep there.

// File: rtl/evreg_pkg.sv
package evreg_pkg;

    typedef struct packed {
        logic ev;
        logic sleep;
        logic wake;
    } evreg_state_t;

    localparam evreg_state_t EVREG_RESET = '{ev: 1'b0, sleep: 1'b0, wake: 1'b0};

endpackage

// File: rtl/evreg_pend_edge.sv
module evreg_pend_edge #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pend_i,
    output logic               rise_any_o
);
    logic [NUM_IRQ-1:0] prev_d, prev_q;
    logic [NUM_IRQ-1:0] rise;

    always_comb begin
        prev_d = pend_i;
        for (int i = 0; i < NUM_IRQ; i++) begin
            rise[i] = pend_i[i] & ~prev_q[i];
        end
        rise_any_o = |rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/evreg_rxev_decode.sv
module evreg_rxev_decode #(
    parameter int CODE_W     = 3,
    parameter int ENTRY_CODE = 1,
    parameter int EXIT_CODE  = 2
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              trace_pwr_i,
    input  logic              halted_i,
    output logic              rxev_o
);
    localparam logic [CODE_W-1:0] ENTRY_V = CODE_W'(ENTRY_CODE);
    localparam logic [CODE_W-1:0] EXIT_V  = CODE_W'(EXIT_CODE);

    logic code_hit;

    always_comb begin
        code_hit = (code_i == ENTRY_V) || (code_i == EXIT_V);
        rxev_o   = halted_i | (trace_pwr_i & code_hit);
    end
endmodule

// File: rtl/evreg_fsm.sv
module evreg_fsm
    import evreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sev_i,
    input  logic pend_rise_i,
    input  logic sev_on_pend_i,
    input  logic exc_entry_i,
    input  logic exc_exit_i,
    input  logic dbg_event_i,
    input  logic dbg_en_i,
    input  logic rxev_i,
    input  logic wfe_i,
    output logic sleeping_o,
    output logic wake_o
);
    evreg_state_t st_d, st_q;
    logic         set_cond;

    always_comb begin
        set_cond = sev_i
                 | (sev_on_pend_i & pend_rise_i)
                 | exc_entry_i
                 | exc_exit_i
                 | (dbg_event_i & dbg_en_i)
                 | rxev_i;

        st_d      = st_q;
        st_d.wake = 1'b0;

        if (st_q.sleep) begin
            if (set_cond) begin
                st_d.sleep = 1'b0;
                st_d.wake  = 1'b1;
                st_d.ev    = 1'b0;
            end
        end else begin
            if (wfe_i && !st_q.ev && !set_cond) begin
                st_d.sleep = 1'b1;
            end
            if (wfe_i && st_q.ev) begin
                st_d.ev = 1'b0;
            end
            if (set_cond) begin
                st_d.ev = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EVREG_RESET;
        else        st_q <= st_d;
    end

    assign sleeping_o = st_q.sleep;
    assign wake_o     = st_q.wake;
endmodule

// File: rtl/evreg_wake_top.sv
module evreg_wake_top #(
    parameter int NUM_IRQ    = 8,
    parameter int CODE_W     = 3,
    parameter int ENTRY_CODE = 1,
    parameter int EXIT_CODE  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sev_local_i,
    input  logic               sev_remote_i,
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic               sev_on_pend_i,
    input  logic               exc_entry_i,
    input  logic               exc_exit_i,
    input  logic               dbg_event_i,
    input  logic               dbg_en_i,
    input  logic [CODE_W-1:0]  istat_code_i,
    input  logic               trace_pwr_i,
    input  logic               halted_i,
    input  logic               wfe_req_i,
    output logic               sleeping_o,
    output logic               wake_o
);
    logic pend_rise;
    logic rxev;
    logic sev_any;

    assign sev_any = sev_local_i | sev_remote_i;

    evreg_pend_edge #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend_i),
        .rise_any_o (pend_rise)
    );

    evreg_rxev_decode #(
        .CODE_W     (CODE_W),
        .ENTRY_CODE (ENTRY_CODE),
        .EXIT_CODE  (EXIT_CODE)
    ) u_rxev (
        .code_i      (istat_code_i),
        .trace_pwr_i (trace_pwr_i),
        .halted_i    (halted_i),
        .rxev_o      (rxev)
    );

    evreg_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sev_i         (sev_any),
        .pend_rise_i   (pend_rise),
        .sev_on_pend_i (sev_on_pend_i),
        .exc_entry_i   (exc_entry_i),
        .exc_exit_i    (exc_exit_i),
        .dbg_event_i   (dbg_event_i),
        .dbg_en_i      (dbg_en_i),
        .rxev_i        (rxev),
        .wfe_i         (wfe_req_i),
        .sleeping_o    (sleeping_o),
        .wake_o        (wake_o)
    );
endmodule

// File: rtl/evreg_wake_checks.sv
module evreg_wake_checks (
    input logic clk,
    input logic rst_n,
    input logic sev_local_i,
    input logic sev_remote_i,
    input logic exc_entry_i,
    input logic halted_i,
    input logic wfe_req_i,
    input logic sleeping_o,
    input logic wake_o
);
    // R9: a wake pulse follows a sleeping cycle and ends the sleep
    a_r9_wake_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (!sleeping_o && $past(sleeping_o)));

    // R9: the wake pulse lasts one cycle
    a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R9: leaving sleep always comes with a wake pulse
    a_r9_exit_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleeping_o) |-> wake_o);

    // R8: sleep is entered only after a WFE request
    a_r8_sleep_needs_wfe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleeping_o) |-> $past(wfe_req_i));

    // R2 / R10: a send-event while awake keeps the core awake
    a_r2_sev_blocks_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping_o && (sev_local_i || sev_remote_i)) |=> !sleeping_o);

    // R4: exception entry while awake keeps the core awake
    a_r4_entry_blocks_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping_o && exc_entry_i) |=> !sleeping_o);

    // R6: halted holds the core out of sleep
    a_r6_halted_blocks_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        halted_i |=> !sleeping_o);
endmodule

bind evreg_wake_top evreg_wake_checks u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .sev_local_i  (sev_local_i),
    .sev_remote_i (sev_remote_i),
    .exc_entry_i  (exc_entry_i),
    .halted_i     (halted_i),
    .wfe_req_i    (wfe_req_i),
    .sleeping_o   (sleeping_o),
    .wake_o       (wake_o)
);

// File: tb/test_evreg_wake_top.sv
module test_evreg_wake_top;
    localparam int NI = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sevl = 0, sevr = 0, son = 0, ent = 0, ext = 0, dbg = 0, den = 0;
    logic tpwr = 0, halted = 0, wfe = 0;
    logic [NI-1:0] pend = '0;
    logic [2:0] code = 3'd0;
    logic sleeping, wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference
    bit m_ev, m_sleep, m_wake;
    logic [NI-1:0] m_prev;

    always #4 clk = ~clk;

    evreg_wake_top i_evreg_wake_top (
        .clk(clk), .rst_n(rst_n),
        .sev_local_i(sevl), .sev_remote_i(sevr),
        .pend_i(pend), .sev_on_pend_i(son),
        .exc_entry_i(ent), .exc_exit_i(ext),
        .dbg_event_i(dbg), .dbg_en_i(den),
        .istat_code_i(code), .trace_pwr_i(tpwr), .halted_i(halted),
        .wfe_req_i(wfe),
        .sleeping_o(sleeping), .wake_o(wake)
    );

    task automatic compare(input string req);
        n_cmp++;
        if (sleeping !== m_sleep || wake !== m_wake) begin
            n_bad++;
            $display("FAIL %s: sleeping=%0b wake=%0b expected sleeping=%0b wake=%0b",
                     req, sleeping, wake, m_sleep, m_wake);
        end
    endtask

    // one clock: inputs already driven; model advances on the edge; compare at negedge
    task automatic step(input string req);
        bit rise, rx, setc;
        @(posedge clk);
        rise   = (pend & ~m_prev) != '0;
        m_prev = pend;
        rx     = halted || (tpwr && (code == 3'd1 || code == 3'd2));
        setc   = sevl || sevr || (son && rise) || ent || ext || (dbg && den) || rx;
        if (m_sleep) begin
            m_wake = 0;
            if (setc) begin m_sleep = 0; m_wake = 1; m_ev = 0; end
        end else begin
            m_wake = 0;
            if (wfe && !m_ev && !setc) m_sleep = 1;
            if (wfe && m_ev) m_ev = 0;
            if (setc) m_ev = 1;
        end
        @(negedge clk);
        compare(req);
        sevl = 0; sevr = 0; ent = 0; ext = 0; dbg = 0; wfe = 0;
    endtask

    task automatic do_wfe(input string req);
        wfe = 1;
        step(req);
    endtask

    task automatic idle(input string req, input int n);
        for (int i = 0; i < n; i++) step(req);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_ev = 0; m_sleep = 0; m_wake = 0; m_prev = '0;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1;
        @(negedge clk);
        compare("R1 after reset");
        do_wfe("R1 first WFE sleeps");
        do_wfe("R9 WFE ignored while asleep");
        idle("R8 stays asleep", 3);

        sevl = 1; step("R2 local sev wakes");
        step("R9 wake single cycle");
        do_wfe("R9 flag cleared on wake");
        sevr = 1; step("R2 remote sev wakes");
        idle("R9 idle", 1);

        // R7: consume a set flag
        sevl = 1; step("R2 local sev while awake");
        do_wfe("R7 WFE consumes flag");
        do_wfe("R7 second WFE sleeps");
        ent = 1; step("R4 entry wakes");
        do_wfe("R4 sleep again");
        ext = 1; step("R4 exit wakes");

        // R5 debug gating
        do_wfe("R5 sleep");
        dbg = 1; den = 0; step("R5 debug ignored when disabled");
        idle("R5 still asleep", 2);
        dbg = 1; den = 1; step("R5 debug wakes when enabled");
        den = 0;

        // R3 pending edges
        do_wfe("R3 sleep");
        son = 0; pend = 8'h04; step("R3 rise ignored when disabled");
        idle("R3 hold", 2);
        son = 1; pend = 8'h0C; step("R3 new rise wakes");
        idle("R3 level held", 4);
        do_wfe("R3 held level does not set");
        pend = 8'h00; idle("R3 drop", 2);
        pend = 8'h80; step("R3 rise at top bit wakes");
        pend = 8'h00; son = 0;

        // R6 decode
        do_wfe("R6 sleep");
        tpwr = 1;
        for (int c = 0; c < 8; c++) begin
            if (c == 1 || c == 2) continue;
            code = 3'(c); step("R6 other code ignored");
        end
        code = 3'd1; tpwr = 0; step("R6 code ignored without trace power");
        code = 3'd2; step("R6 code ignored without trace power");
        tpwr = 1; code = 3'd1; step("R6 code 001 wakes");
        code = 3'd0;
        do_wfe("R6 sleep after 001");
        code = 3'd2; step("R6 code 010 wakes");
        code = 3'd2; wfe = 1; step("R6 code 010 held blocks sleep");
        code = 3'd0; tpwr = 0;
        do_wfe("R6 consume");
        do_wfe("R6 sleep");
        halted = 1; step("R6 halted wakes");
        wfe = 1; step("R6 halted blocks sleep");
        halted = 0;
        do_wfe("R6 consume after halt");

        // R10 set wins over WFE clear
        do_wfe("R10 sleep");
        sevr = 1; step("R10 wake");
        sevl = 1; wfe = 1; step("R10 set with WFE, flag clear");
        do_wfe("R10 flag kept, no sleep");
        do_wfe("R10 now sleeps");
        ent = 1; step("R10 wake");
        sevl = 1; step("R10 set flag");
        ext = 1; wfe = 1; step("R10 set with WFE, flag set");
        do_wfe("R10 flag kept");
        do_wfe("R10 sleeps");
        sevl = 1; step("R10 wake");

        // R11 interrupt handled before WFE
        ent = 1; step("R11 entry");
        idle("R11 handler", 3);
        ext = 1; step("R11 exit");
        idle("R11 return", 2);
        do_wfe("R11 WFE does not sleep");
        do_wfe("R11 next WFE sleeps");
        sevl = 1; step("R11 wake");

        // reset while asleep
        do_wfe("R1 sleep before reset");
        rst_n = 0;
        m_ev = 0; m_sleep = 0; m_wake = 0; m_prev = '0;
        @(negedge clk);
        compare("R1 reset clears sleep");
        rst_n = 1;
        @(negedge clk);
        do_wfe("R1 flag clear after reset");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule